// File: doc/BRIEF.md
# Random-Access Scan Storage Array

This block is a bank of addressable storage cells that each hold one word of state for surrounding logic. In normal operation every cell loads its own slice of the functional data bus whenever the functional enable is high. For test, a parallel address picks out exactly one cell. That cell can be written from the scan data input or read back on the scan output, so no serial chain has to be shifted through.

The address decoder drives one select line per cell. A scan write reaches a cell only when three things are true in the same cycle: test mode is on, the scan strobe is high and the cell's select line is active. The readout multiplexer uses the same select lines and registers the result, which gives one cycle of latency. It works in both modes, so any cell can be watched while the array runs normally, and reading it changes no state. An address at or above the cell count selects nothing and reads back zero.

Top module: `ras_storage_array`

## Requirements
- R1: While reset is asserted and once it has been released, every cell holds 0 and `scan_q` is 0 until the first load or read.
- R2: With `test_mode`=0 and `func_en`=1, cell i takes `func_d[i*CELL_W +: CELL_W]` at the next clock edge. With `func_en`=0 every cell holds its value.
- R3: With `test_mode`=0 the scan strobe `scan_stb` has no effect on any cell.
- R4: With `test_mode`=1 and `scan_stb`=1, the cell whose index equals `scan_addr` takes `scan_d` at the next edge. All other cells keep their values when `func_en`=0.
- R5: With `test_mode`=1, `scan_stb`=1 and `func_en`=1 in the same cycle, the addressed cell takes `scan_d` and every other cell takes its `func_d` slice.
- R6: With `test_mode`=1 and `scan_stb`=0, no scan write happens to any cell.
- R7: `scan_q` is registered. After an edge it shows the value that the cell at the `scan_addr` sampled on that edge held just before that edge. A scan write to the same cell on that edge therefore shows up one cycle later.
- R8: A `scan_addr` of `NUM_CELLS` or more makes `scan_q` read 0 and lets a scan write alter no cell.
- R9: In normal mode with `func_en`=0, stepping `scan_addr` through every cell reads each cell's value on `scan_q` and leaves `func_q` unchanged.
- R10: `scan_addr` is `$clog2(NUM_CELLS)` bits wide. Cell i sits at address i and occupies bits `[i*CELL_W +: CELL_W]` of both `func_d` and `func_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| test_mode | input | 1 | 1 enables scan writes |
| func_en | input | 1 | Functional load enable for all cells |
| func_d | input | NUM_CELLS*CELL_W | Functional data, one slice per cell |
| scan_stb | input | 1 | Scan write strobe (gated scan clock) |
| scan_addr | input | $clog2(NUM_CELLS) | Cell address for scan write and readout |
| scan_d | input | CELL_W | Scan write data |
| func_q | output | NUM_CELLS*CELL_W | Contents of all cells |
| scan_q | output | CELL_W | Registered value of the addressed cell, 0 when out of range |

## Verification
Two functional load patterns give every cell a distinct nibble, so a swapped or shifted slice is exposed. Scan writes go to the first cell, the last cell and an interior cell, each with different data; this separates a correct decoder from one that is off by one or that writes several cells at once. Cycles with a raised strobe in normal mode, with the strobe low in test mode, and with both loads at once isolate the gating and the priority. Address sweeps in both modes, an out-of-range sweep and a read of a cell that is written in the same cycle show the readout latency, the zero fill and that reads do not disturb state.

// File: rtl/ras_pkg.sv
package ras_pkg;
  function automatic int addr_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/ras_rst_sync.sv
module ras_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/ras_addr_decoder.sv
module ras_addr_decoder #(
  parameter int NUM_CELLS = 12,
  parameter int ADDR_W    = 4
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_CELLS-1:0] sel,
  output logic                 in_range
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_CELLS);

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_sel
    assign sel[i] = (addr == ADDR_W'(i));
  end

  assign in_range = ({1'b0, addr} < LIMIT);
endmodule

// File: rtl/ras_cell.sv
module ras_cell #(
  parameter int CELL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              func_en,
  input  logic [CELL_W-1:0] func_d,
  input  logic              scan_we,
  input  logic [CELL_W-1:0] scan_d,
  output logic [CELL_W-1:0] q
);
  logic [CELL_W-1:0] q_nxt;
  logic              q_en;

  always_comb begin
    q_en  = scan_we | func_en;
    q_nxt = scan_we ? scan_d : func_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nxt;
  end

  // R4
  scan_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_we |=> (q == $past(scan_d)));

  // R5
  func_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (func_en && !scan_we) |=> (q == $past(func_d)));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!func_en && !scan_we) |=> $stable(q));
endmodule

// File: rtl/ras_readout.sv
module ras_readout #(
  parameter int NUM_CELLS = 12,
  parameter int CELL_W    = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_CELLS-1:0]        sel,
  input  logic                        in_range,
  input  logic [NUM_CELLS*CELL_W-1:0] cells,
  output logic [CELL_W-1:0]           scan_q
);
  logic [CELL_W-1:0] rd_nxt;

  always_comb begin
    rd_nxt = '0;
    for (int i = 0; i < NUM_CELLS; i++) begin
      rd_nxt = rd_nxt | (cells[i*CELL_W +: CELL_W] & {CELL_W{sel[i]}});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scan_q <= '0;
    else        scan_q <= rd_nxt;
  end

  // R8
  oor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_range |=> (scan_q == '0));
endmodule

// File: rtl/ras_storage_array.sv
module ras_storage_array #(
  parameter int NUM_CELLS = 12,
  parameter int CELL_W    = 4,
  parameter int ADDR_W    = ras_pkg::addr_bits(NUM_CELLS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        test_mode,
  input  logic                        func_en,
  input  logic [NUM_CELLS*CELL_W-1:0] func_d,
  input  logic                        scan_stb,
  input  logic [ADDR_W-1:0]           scan_addr,
  input  logic [CELL_W-1:0]           scan_d,
  output logic [NUM_CELLS*CELL_W-1:0] func_q,
  output logic [CELL_W-1:0]           scan_q
);
  localparam int RST_STAGES = 2;

  logic                 rst_i_n;
  logic [NUM_CELLS-1:0] sel;
  logic                 in_range;
  logic                 scan_arm;

  ras_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_i_n)
  );

  ras_addr_decoder #(.NUM_CELLS(NUM_CELLS), .ADDR_W(ADDR_W)) u_dec (
    .addr     (scan_addr),
    .sel      (sel),
    .in_range (in_range)
  );

  assign scan_arm = test_mode & scan_stb;

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    ras_cell #(.CELL_W(CELL_W)) u_cell (
      .clk     (clk),
      .rst_n   (rst_i_n),
      .func_en (func_en),
      .func_d  (func_d[i*CELL_W +: CELL_W]),
      .scan_we (scan_arm & sel[i]),
      .scan_d  (scan_d),
      .q       (func_q[i*CELL_W +: CELL_W])
    );
  end

  ras_readout #(.NUM_CELLS(NUM_CELLS), .CELL_W(CELL_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .sel      (sel),
    .in_range (in_range),
    .cells    (func_q),
    .scan_q   (scan_q)
  );

  // R3
  normal_no_scan_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!test_mode && !func_en) |=> $stable(func_q));

  // R8
  oor_no_write_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (test_mode && scan_stb && !in_range && !func_en) |=> $stable(func_q));

  // R2
  normal_load_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!test_mode && func_en) |=> (func_q == $past(func_d)));
endmodule

// File: tb/ras_storage_array_tb.sv
module ras_storage_array_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 12;
  localparam int W  = 4;
  localparam int AW = 4;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           test_mode, func_en, scan_stb;
  logic [N*W-1:0] func_d;
  logic [AW-1:0]  scan_addr;
  logic [W-1:0]   scan_d;
  logic [N*W-1:0] func_q;
  logic [W-1:0]   scan_q;

  logic [W-1:0]   model [N];
  logic [W-1:0]   exp_so;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ras_storage_array #(.NUM_CELLS(N), .CELL_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .func_en(func_en),
    .func_d(func_d), .scan_stb(scan_stb), .scan_addr(scan_addr),
    .scan_d(scan_d), .func_q(func_q), .scan_q(scan_q)
  );

  function automatic logic [N*W-1:0] pattern(input int seed, input int step);
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(seed + i*step);
    return v;
  endfunction

  task automatic check_state(input string tag);
    logic [N*W-1:0] exp_q;
    for (int i = 0; i < N; i++) exp_q[i*W +: W] = model[i];
    checks++;
    if (func_q !== exp_q) begin
      errors++;
      $display("FAIL %s func_q actual %h expected %h", tag, func_q, exp_q);
    end
    checks++;
    if (scan_q !== exp_so) begin
      errors++;
      $display("FAIL %s scan_q actual %h expected %h", tag, scan_q, exp_so);
    end
  endtask

  // One clock: drive at negedge, update model, sample at next negedge.
  task automatic cycle(input logic tm, input logic fe, input logic se,
                       input logic [AW-1:0] a, input logic [W-1:0] sd,
                       input logic [N*W-1:0] fd, input string tag);
    test_mode = tm; func_en = fe; scan_stb = se;
    scan_addr = a; scan_d = sd; func_d = fd;
    exp_so = (int'(a) < N) ? model[int'(a)] : '0;
    for (int i = 0; i < N; i++) begin
      if (tm && se && int'(a) == i) model[i] = sd;
      else if (fe)                  model[i] = fd[i*W +: W];
    end
    @(posedge clk);
    @(negedge clk);
    check_state(tag);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; test_mode = 0; func_en = 0; scan_stb = 0;
    scan_addr = '0; scan_d = '0; func_d = '0;
    for (int i = 0; i < N; i++) model[i] = '0;
    exp_so = '0;
    repeat (3) @(negedge clk);
    check_state("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_state("R1 after release");
  endtask

  task automatic t_normal_load;
    cycle(0, 1, 0, 4'd0, 4'h0, pattern(3, 5), "R2 R10 load A");
    cycle(0, 1, 0, 4'd1, 4'h0, pattern(10, 7), "R2 R10 load B");
    cycle(0, 0, 0, 4'd2, 4'h0, pattern(1, 1), "R2 hold");
  endtask

  task automatic t_normal_scan_ignored;
    cycle(0, 0, 1, 4'd3, 4'hF, pattern(0, 0), "R3 strobe in normal");
    cycle(0, 0, 1, 4'd11, 4'h6, pattern(0, 0), "R3 strobe last cell");
  endtask

  task automatic t_scan_write;
    cycle(1, 0, 1, 4'd0, 4'h9, pattern(0, 0), "R4 write cell 0");
    cycle(1, 0, 1, 4'd11, 4'h3, pattern(0, 0), "R4 write last cell");
    cycle(1, 0, 1, 4'd6, 4'hC, pattern(0, 0), "R4 write cell 6");
  endtask

  task automatic t_strobe_needed;
    cycle(1, 0, 0, 4'd4, 4'hE, pattern(0, 0), "R6 no strobe");
  endtask

  task automatic t_priority;
    cycle(1, 1, 1, 4'd5, 4'h1, pattern(8, 3), "R5 scan over func");
  endtask

  task automatic t_readout;
    for (int a = 0; a < N; a++)
      cycle(1, 0, 0, AW'(a), 4'h0, pattern(0, 0), "R7 read sweep");
    cycle(1, 0, 1, 4'd2, 4'hA, pattern(0, 0), "R7 read during write");
    cycle(1, 0, 0, 4'd2, 4'h0, pattern(0, 0), "R7 read after write");
  endtask

  task automatic t_normal_observe;
    for (int a = N - 1; a >= 0; a--)
      cycle(0, 0, 0, AW'(a), 4'h0, pattern(0, 0), "R9 observe normal");
  endtask

  task automatic t_out_of_range;
    for (int a = N; a < (1 << AW); a++)
      cycle(1, 0, 1, AW'(a), 4'h7, pattern(0, 0), "R8 out of range");
    cycle(1, 0, 0, 4'd1, 4'h0, pattern(0, 0), "R8 back in range");
  endtask

  initial begin
    t_reset();
    t_normal_load();
    t_normal_scan_ignored();
    t_scan_write();
    t_strobe_needed();
    t_priority();
    t_readout();
    t_normal_observe();
    t_out_of_range();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule